// File: doc/BRIEF.md
# DRAM Controller Command Sequencer

This block is the software-facing front end of an SDRAM/DDR controller. Firmware drives it through a small word-addressed register bus. It uses the bus to move the controller between a configuration state and a ready state, to load the timing registers, and to step the memory through its power-up initialisation one command at a time. A typical power-up runs as follows. The controller is placed in config. The timing registers are loaded. Software then issues these commands in order: NOP, precharge-all, two auto-refreshes, the extended mode-register set, and the normal mode-register set. Finally it requests ready and polls the status register until the state field reads ready.

Each accepted command appears on an abstract DRAM command bus (chip select, RAS, CAS, WE, bank and row address) for exactly one cycle. A command-dependent gap then follows, during which a busy flag is raised and further commands are refused. Once in the ready state, the block issues auto-refresh by itself each time a programmable period elapses. The refresh counter is frozen while the block is in config.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset the state field (status bits [1:0]) reads 2'b00 (config), the busy bit (status bit 2) and the error bit (status bit 3) read 0, all command pins are high with bank and address 0, and the refresh-period register (byte offset 0x010) reads 1038.
- R2: Writing 3'b100 to bits [2:0] of the control register (offset 0x004) returns the block to config; the status then reads 2'b00 from the next cycle. Writing 3'b000 requests the ready state, which reads 2'b01.
- R3: A ready request made while busy is held. The state changes to 2'b01 one cycle after the busy bit first reads 0, and not before.
- R4: In config and not busy, a write to the command register (offset 0x008) issues the command chosen by bits [19:18]. The command is on the bus in the cycle after the write, for one cycle only. The pins {cs_n, ras_n, cas_n, we_n} are: 2'b11 NOP = 0111, 2'b00 precharge-all = 0010, 2'b01 auto-refresh = 0001, 2'b10 mode set = 0000.
- R5: A mode set drives the bank from bits [17:16] and the row address from the low 14 bits of the written word. Precharge-all drives only address bit 10 high, with bank 0. NOP and auto-refresh drive bank and address 0.
- R6: After a command is issued, the busy bit is high for t_RP cycles after precharge-all, t_RFC cycles after auto-refresh and t_MRD cycles after a mode set. A NOP leaves it low.
- R7: A command write while busy issues nothing and sets the error bit.
- R8: A command write in the ready state issues nothing and sets the error bit. The error bit stays set until reset.
- R9: Timing registers are written in config and read back. CAS latency is at 0x014, t_MRD, t_RAS, t_RC, t_RCD, t_RFC and t_RP are at 0x01C to 0x030 in 4-byte steps, and each keeps its low 6 bits. The refresh period at 0x010 keeps its low 16 bits. Offset 0x018 reads 0. Writes to these registers in the ready state are ignored.
- R10: In the ready state an auto-refresh is issued every refresh-period cycles. In config no auto-refresh is issued unless software writes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address; bits [1:0] are ignored |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | 2 | Bank address |
| dram_addr | output | 14 | Row address |

## Verification
The bound checker watches several rules on every cycle:
- A deselected bus keeps RAS, CAS and WE high.
- Every precharge-all on the bus coincides with a running gap.
- The state never rises to ready while a gap is still counting.
- The error flag never clears.
- A command write in ready is never followed by a software command.
- Config never emits an unrequested refresh.

Only the bench scenarios can show the rest: the exact pin patterns, bank and address for every opcode-bank pairing; the length of each gap; the one-cycle hold-off of a deferred ready request; the refresh interval; and register read-back.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic [1:0] {
      OP_PALL = 2'b00,
      OP_REF  = 2'b01,
      OP_MRS  = 2'b10,
      OP_NOP  = 2'b11
   } dcs_op_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } dcs_pins_t;

   localparam dcs_pins_t PINS_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

   // controller-command codes
   localparam logic [2:0] CTL_CONFIG = 3'b100;
   localparam logic [2:0] CTL_READY  = 3'b000;

   // word indexes on the register bus
   localparam int W_STAT   = 0;
   localparam int W_CTRL   = 1;
   localparam int W_DIRECT = 2;
   localparam int W_REFPRD = 4;
   localparam int W_TBASE  = 5;

   // timing slots starting at W_TBASE
   localparam int N_TSLOT = 8;
   localparam int TS_CAS  = 0;
   localparam int TS_RSVD = 1;
   localparam int TS_MRD  = 2;
   localparam int TS_RFC  = 6;
   localparam int TS_RP   = 7;

   // command-word fields
   localparam int OP_LSB = 18;
   localparam int BA_LSB = 16;
   localparam int PALL_BIT = 10;

   function automatic dcs_pins_t op_pins(input dcs_op_e op);
      dcs_pins_t p;
      case (op)
         OP_NOP:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
         OP_PALL: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         OP_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
         default: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/dcs_down_counter.sv
module dcs_down_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (en && (cnt != '0))
         cnt <= cnt - W'(1);
   end

endmodule

// File: rtl/dcs_timing_regs.sv
module dcs_timing_regs
   import dcs_pkg::*;
#(
   parameter int IDX_W   = 10,
   parameter int TIME_W  = 6,
   parameter int REF_W   = 16,
   parameter int REF_RST = 1038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [REF_W-1:0]  wdata,
   output logic [REF_W-1:0]  rd_data,
   output logic [REF_W-1:0]  refresh_prd,
   output logic [TIME_W-1:0] t_mrd,
   output logic [TIME_W-1:0] t_rfc,
   output logic [TIME_W-1:0] t_rp
);

   localparam int SL_W = $clog2(N_TSLOT);

   logic [TIME_W-1:0] slot_q [N_TSLOT];
   logic [IDX_W-1:0]  rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         refresh_prd <= REF_W'(REF_RST);
      else if (wr_en && idx == IDX_W'(W_REFPRD))
         refresh_prd <= wdata;
   end

   generate
      for (genvar i = 0; i < N_TSLOT; i++) begin : g_slot
         if (i == TS_RSVD) begin : g_rsvd
            assign slot_q[i] = '0;
         end else begin : g_reg
            logic [TIME_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (wr_en && idx == IDX_W'(W_TBASE + i))
                  q <= wdata[TIME_W-1:0];
            end
            assign slot_q[i] = q;
         end
      end
   endgenerate

   assign rel = idx - IDX_W'(W_TBASE);

   always_comb begin
      rd_data = '0;
      if (idx == IDX_W'(W_REFPRD))
         rd_data = refresh_prd;
      else if (rel < IDX_W'(N_TSLOT))
         rd_data = REF_W'(slot_q[rel[SL_W-1:0]]);
   end

   assign t_mrd = slot_q[TS_MRD];
   assign t_rfc = slot_q[TS_RFC];
   assign t_rp  = slot_q[TS_RP];

endmodule

// File: rtl/dcs_cmd_drive.sv
module dcs_cmd_drive
   import dcs_pkg::*;
#(
   parameter int ROW_W  = 14,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  dcs_op_e           op,
   input  logic [BANK_W-1:0] ba_in,
   input  logic [ROW_W-1:0]  row_in,
   output dcs_pins_t         pins,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr
);

   localparam logic [ROW_W-1:0] PALL_ADDR = ROW_W'(1) << PALL_BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins <= PINS_IDLE;
         ba   <= '0;
         addr <= '0;
      end else if (issue) begin
         pins <= op_pins(op);
         ba   <= (op == OP_MRS) ? ba_in : '0;
         case (op)
            OP_MRS:  addr <= row_in;
            OP_PALL: addr <= PALL_ADDR;
            default: addr <= '0;
         endcase
      end else begin
         pins <= PINS_IDLE;
         ba   <= '0;
         addr <= '0;
      end
   end

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
   import dcs_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter int ROW_W   = 14,
   parameter int BANK_W  = 2,
   parameter int TIME_W  = 6,
   parameter int REF_W   = 16,
   parameter int REF_RST = 1038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              dram_cs_n,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [BANK_W-1:0] dram_ba,
   output logic [ROW_W-1:0]  dram_addr
);

   localparam int IDX_W = ADDR_W - 2;

   generate
      if (ROW_W <= PALL_BIT) begin : g_bad_row
         $error("ROW_W must exceed the precharge-all address bit");
      end
      if (BANK_W != 2) begin : g_bad_bank
         $error("BANK_W must be 2 to match the command-word bank field");
      end
      if (DATA_W <= OP_LSB + 2 || DATA_W < REF_W) begin : g_bad_data
         $error("DATA_W too narrow for the command word or refresh period");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
      if (REF_W < 2 || REF_RST >= (1 << REF_W)) begin : g_bad_ref
         $error("REF_W too narrow for REF_RST");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              wr_ctrl, wr_dir, wr_tim;
   logic              ready_q, pend_q, err_q;
   logic              busy, want_ready, ready_go;
   logic              dir_ok, dir_bad, ref_due, issue;
   dcs_op_e           sw_op, issue_op;
   logic [TIME_W-1:0] gap_val, gap_cnt;
   logic [TIME_W-1:0] t_mrd, t_rfc, t_rp;
   logic [REF_W-1:0]  refresh_prd, ref_cnt, tim_rd;
   dcs_pins_t         pins;
   logic              unused_bits;

   assign unused_bits = ^{reg_addr, reg_wdata};

   assign idx     = reg_addr[ADDR_W-1:2];
   assign wr_ctrl = reg_wr && idx == IDX_W'(W_CTRL);
   assign wr_dir  = reg_wr && idx == IDX_W'(W_DIRECT);
   assign wr_tim  = reg_wr && !ready_q;
   assign sw_op   = dcs_op_e'(reg_wdata[OP_LSB+1:OP_LSB]);

   assign busy    = gap_cnt != '0;
   assign dir_ok  = wr_dir && !ready_q && !busy;
   assign dir_bad = wr_dir && !dir_ok;
   assign ref_due = ready_q && (ref_cnt <= REF_W'(1));
   assign issue   = dir_ok || ref_due;
   assign issue_op = ref_due ? OP_REF : sw_op;

   always_comb begin
      case (issue_op)
         OP_PALL: gap_val = t_rp;
         OP_REF:  gap_val = t_rfc;
         OP_MRS:  gap_val = t_mrd;
         default: gap_val = '0;
      endcase
   end

   // controller state: config <-> ready, ready deferred past any gap
   assign want_ready = (wr_ctrl && reg_wdata[2:0] == CTL_READY) || pend_q;
   assign ready_go   = want_ready && !busy && !ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         pend_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         err_q <= err_q | dir_bad;
         if (wr_ctrl && reg_wdata[2:0] == CTL_CONFIG) begin
            ready_q <= 1'b0;
            pend_q  <= 1'b0;
         end else if (ready_go) begin
            ready_q <= 1'b1;
            pend_q  <= 1'b0;
         end else begin
            pend_q  <= want_ready && !ready_q;
         end
      end
   end

   dcs_timing_regs #(
      .IDX_W(IDX_W), .TIME_W(TIME_W), .REF_W(REF_W), .REF_RST(REF_RST)
   ) u_tregs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_tim), .idx(idx),
      .wdata(reg_wdata[REF_W-1:0]), .rd_data(tim_rd), .refresh_prd(refresh_prd),
      .t_mrd(t_mrd), .t_rfc(t_rfc), .t_rp(t_rp)
   );

   dcs_down_counter #(.W(TIME_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(issue), .load_val(gap_val),
      .en(1'b1), .cnt(gap_cnt)
   );

   dcs_down_counter #(.W(REF_W)) u_refresh (
      .clk(clk), .rst_n(rst_n), .load(ready_go || ref_due), .load_val(refresh_prd),
      .en(ready_q), .cnt(ref_cnt)
   );

   dcs_cmd_drive #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_drive (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(issue_op),
      .ba_in(reg_wdata[BA_LSB+BANK_W-1:BA_LSB]), .row_in(reg_wdata[ROW_W-1:0]),
      .pins(pins), .ba(dram_ba), .addr(dram_addr)
   );

   assign dram_cs_n  = pins.cs_n;
   assign dram_ras_n = pins.ras_n;
   assign dram_cas_n = pins.cas_n;
   assign dram_we_n  = pins.we_n;

   always_comb begin
      if (idx == IDX_W'(W_STAT))
         reg_rdata = DATA_W'({err_q, busy, 1'b0, ready_q});
      else
         reg_rdata = DATA_W'(tim_rd);
   end

endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
   parameter int TIME_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_dir,
   input logic              ready_q,
   input logic [TIME_W-1:0] gap_cnt,
   input logic              err_q,
   input logic [TIME_W-1:0] t_rp,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n
);

   // R1
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (ras_n && cas_n && we_n));

   // R6
   pall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !ras_n && cas_n && !we_n && t_rp != '0) |-> (gap_cnt != '0));

   // R3
   ready_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> ($past(gap_cnt) == '0));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R8
   ready_no_sw_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dir && ready_q) |=> (cs_n || (!cas_n && we_n)));

   // R10
   cfg_no_auto_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_q && $past(!ready_q) && !cs_n && !ras_n && !cas_n && we_n) |-> $past(wr_dir));

endmodule

bind dram_cmd_seq dcs_chk #(.TIME_W(TIME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .ready_q(ready_q),
   .gap_cnt(gap_cnt), .err_q(err_q), .t_rp(t_rp),
   .cs_n(dram_cs_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n)
);

// File: tb/sim_dram_cmd_seq.sv
`timescale 1ns/1ps
module sim_dram_cmd_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cs_n, ras_n, cas_n, we_n;
   logic [1:0]  ba;
   logic [13:0] addr;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dram_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dram_cs_n(cs_n), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
      .dram_ba(ba), .dram_addr(addr)
   );

   localparam logic [11:0] A_STAT = 12'h000, A_CTRL = 12'h004, A_DIR = 12'h008,
                           A_REF = 12'h010, A_CAS = 12'h014;
   localparam int PRD = 20, TRP = 3, TRFC = 5, TMRD = 2;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      #1 reg_wr = 1'b0; reg_addr = A_STAT;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = A_STAT;
   endtask

   function automatic logic [3:0] exp_pins(input int op);
      case (op)
         3: return 4'b0111;
         0: return 4'b0010;
         1: return 4'b0001;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic int exp_gap(input int op);
      case (op)
         0: return TRP;
         1: return TRFC;
         2: return TMRD;
         default: return 0;
      endcase
   endfunction

   // issue one command in config and check pins, bank, address, one-cycle width, gap
   task automatic issue(input logic [31:0] d);
      int op, n;
      logic [1:0] eb;
      logic [13:0] ea;
      op = int'(d[19:18]);
      eb = (op == 2) ? d[17:16] : 2'b00;
      ea = (op == 2) ? d[13:0] : (op == 0) ? 14'h0400 : 14'h0000;
      wr(A_DIR, d);
      @(negedge clk);
      chk({cs_n, ras_n, cas_n, we_n} == exp_pins(op), "R4 pins", {cs_n, ras_n, cas_n, we_n}, exp_pins(op));
      chk(ba == eb, "R5 bank", ba, eb);
      chk(addr == ea, "R5 addr", addr, ea);
      n = reg_rdata[2] ? 1 : 0;
      @(negedge clk);
      chk(cs_n == 1'b1, "R4 one cycle", cs_n, 1);
      while (reg_rdata[2]) begin
         n++;
         @(negedge clk);
      end
      chk(n == exp_gap(op), "R6 gap", n, exp_gap(op));
   endtask

   task automatic load_timing();
      logic [31:0] d, v, e;
      for (int s = 0; s < 8; s++) begin
         v = 32'hABCD_EF00 | 32'(s * 9 + 1);
         e = (s == 1) ? 32'h0 : {26'h0, v[5:0]};
         wr(A_CAS + 12'(4 * s), v);
         rd(A_CAS + 12'(4 * s), d);
         chk(d == e, "R9 slot readback", d, e);
      end
      wr(A_REF, 32'hFFFF_0000 | PRD);
      rd(A_REF, d);
      chk(d == PRD, "R9 refresh readback", d, PRD);
      wr(12'h030, TRP);
      wr(12'h02C, TRFC);
      wr(12'h01C, TMRD);
   endtask

   task automatic do_reset();
      logic [31:0] d;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(reg_rdata[3:0] == 4'b0000, "R1 status", reg_rdata[3:0], 0);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b1111 && ba == 0 && addr == 0, "R1 pins",
          {cs_n, ras_n, cas_n, we_n, ba, addr}, 20'hF0000);
      rd(A_REF, d);
      chk(d == 1038, "R1 refresh reset", d, 1038);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int t[3];
      int k, nref;
      do_reset();
      load_timing();

      // sweep every opcode with every bank
      for (int op = 0; op < 4; op++)
         for (int b = 0; b < 4; b++)
            issue((32'(op) << 18) | (32'(b) << 16) | (32'((op * 4 + b) * 613 + 7) & 32'hFFFF));

      // R7: write while busy is dropped
      chk(reg_rdata[3] == 1'b0, "R7 error clear before", reg_rdata[3], 0);
      wr(A_DIR, 32'h0000_0000);
      wr(A_DIR, 32'h000C_0000);
      @(negedge clk);
      chk(cs_n == 1'b1, "R7 dropped cmd", cs_n, 1);
      chk(reg_rdata[3] == 1'b1, "R7 error set", reg_rdata[3], 1);

      // fresh start, full power-up
      do_reset();
      load_timing();
      issue(32'h000C_0000);
      issue(32'h0000_0000);
      issue(32'h0004_0000);
      issue(32'h0004_0000);
      issue(32'h000A_0000);
      issue(32'h0008_0032);

      // R3: ready request during a refresh gap
      wr(A_DIR, 32'h0004_0000);
      wr(A_CTRL, 32'h0);
      @(negedge clk);
      while (reg_rdata[2]) begin
         chk(reg_rdata[1:0] == 2'b00, "R3 held while busy", reg_rdata[1:0], 0);
         @(negedge clk);
      end
      chk(reg_rdata[1:0] == 2'b00, "R3 first idle cycle", reg_rdata[1:0], 0);
      @(negedge clk);
      chk(reg_rdata[1:0] == 2'b01, "R2 ready state", reg_rdata[1:0], 1);

      // R10: periodic refresh
      k = 0;
      for (int i = 0; i < 200 && k < 3; i++) begin
         @(negedge clk);
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) begin
            t[k] = cyc;
            k++;
         end
      end
      chk(k == 3, "R10 refresh seen", k, 3);
      chk(t[1] - t[0] == PRD, "R10 interval a", t[1] - t[0], PRD);
      chk(t[2] - t[1] == PRD, "R10 interval b", t[2] - t[1], PRD);

      // R9: timing write ignored in ready
      wr(12'h030, 32'd9);
      rd(12'h030, d);
      chk(d == TRP, "R9 ready write ignored", d, TRP);

      // R8: command write in ready
      wr(A_DIR, 32'h0008_0011);
      @(negedge clk);
      chk({cs_n, ras_n, cas_n, we_n} != 4'b0000, "R8 no mode set", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
      chk(reg_rdata[3] == 1'b1, "R8 error set", reg_rdata[3], 1);
      chk(reg_rdata[1:0] == 2'b01, "R8 still ready", reg_rdata[1:0], 1);

      // R2: back to config, R10: refresh stops
      wr(A_CTRL, 32'h4);
      @(negedge clk);
      chk(reg_rdata[1:0] == 2'b00, "R2 config state", reg_rdata[1:0], 0);
      nref = 0;
      for (int i = 0; i < 3 * PRD; i++) begin
         @(negedge clk);
         if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) nref++;
      end
      chk(nref == 0, "R10 frozen in config", nref, 0);
      chk(reg_rdata[3] == 1'b1, "R8 error sticky", reg_rdata[3], 1);
      issue(32'h000C_0000);

      finish_run();
   end

endmodule